// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the periodic one-cycle enable tick that paces a UART's bit shifter. It holds one 32-bit configuration register that carries a divider count, a divider enable, a reference source select and a two-bit prescale select for the crystal path. The block has no clock other than its own. Both reference inputs arrive as clock-enable strobes in that clock domain: one comes from a crystal-derived reference and one from an already divided system clock. The logic is therefore fully synchronous.

On the crystal path, the strobe first passes through a small prescaler. Its ratio table is not monotonic: select 0 divides by 3, select 1 passes every strobe, and selects 2 and 3 divide by 2. The chosen reference then feeds a counter that emits a tick every N+1 reference strobes, where N is the divider field. With a 24 MHz crystal strobe and the /3 prescale, N equals 8 MHz divided by the baud rate, minus one.

Two parameters give a reduced variant. In the first, the prescale bits are tied to zero. In the second, the source bit is fixed at its reset value. Software should change the setting only when the transmitter is idle. Any write restarts the timing from zero.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, tick_o is 0 and rd_data_o reads 0, except that bit 24 reads SRC_RST when SRC_RO=1.
- R2: The register fields are: bits [22:0] the divider N, bit 23 the divider enable, bit 24 the source (1 = crystal path, 0 = system path), and bits [27:26] the prescale select. Bits 25 and [31:28] always read 0. A write with wr_en_i=1 stores wr_data_i on that clock edge, and rd_data_o reflects it from the next cycle.
- R3: While bit 23 is 0, tick_o stays 0 whatever the strobes do.
- R4: With bit 24 = 0, tick_o pulses once per N+1 sys_stb_i strobes.
- R5: With bit 24 = 1, the crystal prescale ratio is 3 for select 00, 1 for select 01, and 2 for selects 10 and 11. tick_o pulses once per ratio*(N+1) xtal_stb_i strobes.
- R6: tick_o is high for exactly the one cycle that follows the clock edge on which the period-completing strobe was sampled.
- R7: A register write clears the prescaler and the divider counter. The first tick after a write therefore comes a full new period after it, and tick_o is 0 in the cycle after the write.
- R8: With LEGACY=1, bits [27:26] read 0, writes to them are ignored, and the crystal path always divides by 3.
- R9: With SRC_RO=1, bit 24 keeps the value SRC_RST, and writes to it are ignored.
- R10: With select 01 and N=0 on the crystal path, a tick follows every xtal_stb_i strobe.
- R11: Strobes on the source that is not selected have no effect on tick_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| xtal_stb_i | input | 1 | Crystal-derived reference enable strobe |
| sys_stb_i | input | 1 | Divided system-clock reference enable strobe |
| tick_o | output | 1 | One-cycle baud tick |
| rd_data_o | output | 32 | Register read-back |

## Verification
The hardest situation to reach is a write that lands partway through a period. In that case the counters hold a non-zero residue from the earlier setting, and the tick must still wait a full new period. The bench creates this by running each configuration straight after the previous one without a reset. It also includes one case that writes after only part of a period has elapsed. Throughout, the strobe of the unselected source is held high, so any leak from that source shows up as an extra tick.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  localparam int unsigned DIV_W   = 23;
  localparam int unsigned EN_BIT  = 23;
  localparam int unsigned SRC_BIT = 24;
  localparam int unsigned PS_LO   = 26;
  localparam int unsigned PS_W    = 2;
  localparam int unsigned RATIO_W = 2;

  // non-monotonic prescale table
  function automatic logic [RATIO_W-1:0] presc_ratio(input logic [PS_W-1:0] sel);
    case (sel)
      2'b00:   presc_ratio = 2'd3;
      2'b01:   presc_ratio = 2'd1;
      default: presc_ratio = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_tick_pkg::*;
#(
  parameter bit LEGACY  = 1'b0,
  parameter bit SRC_RO  = 1'b0,
  parameter bit SRC_RST = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [31:0]      wr_data_i,
  output logic [DIV_W-1:0] div_o,
  output logic             en_o,
  output logic             src_o,
  output logic [PS_W-1:0]  psel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= '0;
      en_o  <= 1'b0;
    end else if (wr_en_i) begin
      div_o <= wr_data_i[DIV_W-1:0];
      en_o  <= wr_data_i[EN_BIT];
    end
  end

  generate
    if (SRC_RO) begin : g_src_ro
      assign src_o = SRC_RST;
    end else begin : g_src_rw
      logic src_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      src_q <= SRC_RST;
        else if (wr_en_i) src_q <= wr_data_i[SRC_BIT];
      end
      assign src_o = src_q;
    end

    if (LEGACY) begin : g_ps_ro
      assign psel_o = '0;
    end else begin : g_ps_rw
      logic [PS_W-1:0] ps_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      ps_q <= '0;
        else if (wr_en_i) ps_q <= wr_data_i[PS_LO +: PS_W];
      end
      assign psel_o = ps_q;
    end
  endgenerate
endmodule

// File: rtl/baud_presc.sv
module baud_presc
  import baud_tick_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            stb_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            stb_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] last;

  assign last  = presc_ratio(sel_i) - RATIO_W'(1);
  assign stb_o = stb_i && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (stb_i)  cnt_q <= stb_o ? '0 : cnt_q + RATIO_W'(1);
  end
endmodule

// File: rtl/baud_div_cnt.sv
module baud_div_cnt #(
  parameter int unsigned W = 23
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         stb_i,
  input  logic [W-1:0] n_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         hit;

  assign hit = stb_i && (cnt_q == n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= hit;
      if (stb_i) cnt_q <= hit ? '0 : cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter bit LEGACY  = 1'b0,
  parameter bit SRC_RO  = 1'b0,
  parameter bit SRC_RST = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  input  logic        xtal_stb_i,
  input  logic        sys_stb_i,
  output logic        tick_o,
  output logic [31:0] rd_data_o
);
  logic [DIV_W-1:0] div;
  logic             en, src;
  logic [PS_W-1:0]  psel;
  logic             clr, xtal_ref, ref_stb;

  baud_cfg_reg #(.LEGACY(LEGACY), .SRC_RO(SRC_RO), .SRC_RST(SRC_RST)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .div_o(div), .en_o(en), .src_o(src), .psel_o(psel)
  );

  // a write or a disabled divider restarts all timing
  assign clr = wr_en_i || !en;

  baud_presc i_presc (
    .clk_i, .rst_ni, .clr_i(clr), .stb_i(xtal_stb_i), .sel_i(psel), .stb_o(xtal_ref)
  );

  assign ref_stb = src ? xtal_ref : sys_stb_i;

  baud_div_cnt #(.W(DIV_W)) i_div (
    .clk_i, .rst_ni, .clr_i(clr), .stb_i(ref_stb), .n_i(div), .tick_o
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[DIV_W-1:0]        = div;
    rd_data_o[EN_BIT]           = en;
    rd_data_o[SRC_BIT]          = src;
    rd_data_o[PS_LO +: PS_W]    = psel;
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter bit LEGACY  = 1'b0,
  parameter bit SRC_RO  = 1'b0,
  parameter bit SRC_RST = 1'b0
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        xtal_stb_i,
  input logic        sys_stb_i,
  input logic        tick_o,
  input logic [31:0] rd_data_o
);
  p_unused_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[31:28] == 4'd0 && !rd_data_o[25]);

  p_disabled_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[23] |-> !tick_o);

  p_tick_from_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(rd_data_o[24] ? xtal_stb_i : sys_stb_i));

  p_write_restarts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !tick_o);

  p_legacy_ps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    LEGACY |-> rd_data_o[27:26] == 2'b00);

  p_src_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    SRC_RO |-> rd_data_o[24] == SRC_RST);
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.LEGACY(LEGACY), .SRC_RO(SRC_RO), .SRC_RST(SRC_RST)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .xtal_stb_i(xtal_stb_i),
  .sys_stb_i(sys_stb_i), .tick_o(tick_o), .rd_data_o(rd_data_o)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_en_l = 1'b0;
  logic [31:0] wr_data = '0, wr_data_l = '0;
  logic        xs = 1'b0, ss = 1'b0, xs_l = 1'b0;
  logic        tick, tick_l;
  logic [31:0] rd, rd_l;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  baud_tick_gen i_baud_tick_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .xtal_stb_i(xs), .sys_stb_i(ss), .tick_o(tick), .rd_data_o(rd)
  );

  baud_tick_gen #(.LEGACY(1'b1), .SRC_RO(1'b1), .SRC_RST(1'b1)) i_baud_tick_gen_leg (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_l), .wr_data_i(wr_data_l),
    .xtal_stb_i(xs_l), .sys_stb_i(1'b1), .tick_o(tick_l), .rd_data_o(rd_l)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio(input int sel);
    if (sel == 0) return 3;
    if (sel == 1) return 1;
    return 2;
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one check per run: tick must match k % P == 0 after every strobe, 0 in gaps
  task automatic run(input int src, input int psel, input int n, input bit en,
                     input int nstb, input int gap, input string req);
    logic [31:0] cfg;
    int p, errs, first_k, first_a, first_e;
    cfg = '0;
    cfg[22:0] = n[22:0]; cfg[23] = en; cfg[24] = src[0]; cfg[27:26] = psel[1:0];
    wr(cfg);
    chk(tick == 1'b0, req, "tick after write", tick, 0);
    p = (src != 0 ? ratio(psel) : 1) * (n + 1);
    errs = 0; first_k = 0; first_a = 0; first_e = 0;
    for (int k = 1; k <= nstb; k++) begin
      if (src != 0) begin xs = 1'b1; ss = 1'b1; end
      else          begin ss = 1'b1; xs = 1'b1; end
      @(posedge clk); @(negedge clk);
      begin
        bit e;
        e = en && (k % p == 0);
        if (tick !== e) begin
          if (errs == 0) begin first_k = k; first_a = int'(tick); first_e = int'(e); end
          errs++;
        end
      end
      if (src != 0) xs = 1'b0; else ss = 1'b0;
      for (int g = 0; g < gap; g++) begin
        @(posedge clk); @(negedge clk);
        if (tick !== 1'b0) begin
          if (errs == 0) begin first_k = k; first_a = int'(tick); first_e = 0; end
          errs++;
        end
      end
    end
    xs = 1'b0; ss = 1'b0;
    if (errs != 0) $display("  at strobe %0d src=%0d sel=%0d n=%0d", first_k, src, psel, n);
    chk(errs == 0, req, "tick pattern", first_a, first_e);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd == 32'h0 && tick == 1'b0, "R1", "reset readback", rd, 0);
    chk(rd_l == 32'h0100_0000 && tick_l == 1'b0, "R1", "reset readback legacy", rd_l, 32'h0100_0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field layout
    wr(32'hFFFF_FFFF);
    chk(rd == 32'h0DFF_FFFF, "R2", "readback all ones", rd, 32'h0DFF_FFFF);
    wr(32'h0000_0000);
    chk(rd == 32'h0, "R2", "readback zero", rd, 0);

    // R3 disabled divider
    run(0, 0, 0, 1'b0, 20, 0, "R3");
    run(1, 1, 0, 1'b0, 20, 1, "R3");

    // R4 system path sweep, R11 via crystal strobe held high
    for (int n = 0; n < 5; n++) run(0, 2, n, 1'b1, 3 * (n + 1) + 1, n % 2, "R4");

    // R5 crystal path sweep over every select, R6 exact cycle, R11 system strobe high
    for (int s = 0; s < 4; s++)
      for (int n = 0; n < 3; n++)
        run(1, s, n, 1'b1, 3 * ratio(s) * (n + 1) + 2, (s + n) % 2, "R5");

    // R10 prescale 1, N=0: tick after each strobe
    run(1, 1, 0, 1'b1, 16, 0, "R10");
    run(1, 1, 0, 1'b1, 8, 2, "R10");

    // R7 rewrite mid-period: residue must not shorten the next period
    run(0, 0, 3, 1'b1, 2, 0, "R7");
    run(0, 0, 3, 1'b1, 9, 0, "R7");
    run(1, 0, 2, 1'b1, 5, 1, "R7");
    run(1, 0, 2, 1'b1, 19, 0, "R7");

    // R11 only the unselected strobe toggles
    wr(32'h0080_0000);
    begin
      int cnt = 0;
      for (int k = 0; k < 20; k++) begin
        xs = 1'b1; @(posedge clk); @(negedge clk);
        if (tick) cnt++;
      end
      xs = 1'b0;
      chk(cnt == 0, "R11", "ticks from unselected source", cnt, 0);
    end

    // R8 / R9 legacy instance
    wr_en_l = 1'b1; wr_data_l = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk); wr_en_l = 1'b0;
    chk(rd_l == 32'h01FF_FFFF, "R8", "legacy readback ones", rd_l, 32'h01FF_FFFF);
    wr_en_l = 1'b1; wr_data_l = 32'h0480_0001; // sel 01, src 0, N=1
    @(posedge clk); @(negedge clk); wr_en_l = 1'b0;
    chk(rd_l == 32'h0180_0001, "R9", "source bit kept", rd_l, 32'h0180_0001);
    begin
      int cnt = 0, first = 0;
      for (int k = 1; k <= 12; k++) begin
        xs_l = 1'b1; @(posedge clk); @(negedge clk);
        if (tick_l) begin cnt++; if (first == 0) first = k; end
      end
      xs_l = 1'b0;
      chk(first == 6, "R8", "legacy first tick strobe", first, 6);
      chk(cnt == 2, "R9", "legacy crystal path ticks", cnt, 2);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule